// File: doc/BRIEF.md
# Strap-Configured Management Address Bridge

This block is the switch-side front end of a management register interface. A host presents single accesses as a parallel request (PHY address, register address, write data and a read or write strobe), and the bridge decides whether the access is meant for this switch and how to carry it out. The decision depends on a set of strap inputs that hold the switch's own even management address and a flag that selects a shared-bus variant.

With an all-zero strap the switch owns the whole 32-address space, and each PHY address reaches the internal device with the same number. With the shared-bus flag set, only the top address bit of the strap counts, the switch owns one half of the space, and the device number is the offset inside that half. With any other strap the switch answers at one address only and offers a two-register window: a command register and a data register. Software loads data, writes a command with the busy bit set, polls until busy drops, then collects read results from the data register.

Internal devices are reached over a simple valid/ready register bus. Every host access ends with a one-cycle acknowledge that carries read data when the access was a read.

Top module: `smi_bridge`

## Requirements
- R1: After reset the command register reads 0x0000 (busy clear) and no internal access is made until the host starts one.
- R2: With the shared-bus flag low and the strap zero, an access at any PHY address P with register R reaches internal device P, register R; reads return the device data and writes store the host data there.
- R3: With the shared-bus flag high, the bridge answers only when PHY address bit 4 equals strap bit 3 (the strap's address bit 4); device number is PHY bits 3:0; the other strap bits have no effect.
- R4: With the shared-bus flag low and a non-zero strap S, the bridge answers only at PHY address 2*S; register 0 is the command register and register 1 the data register. Command layout: bit 15 busy, bits 14:12 read 0, bits 11:10 opcode (01 write, 10 read), bits 9:5 device, bits 4:0 register.
- R5: A command write with bit 15 set and opcode 01 writes the data register value to the addressed device register; busy reads 1 until that internal access completes, then 0.
- R6: A command write with bit 15 set and opcode 10 reads the addressed device register; once busy reads 0, the data register holds the result.
- R7: A command with bit 15 set and opcode 00 or 11 starts no internal access and busy is high for exactly one cycle; a command with bit 15 clear only stores its fields and starts no access.
- R8: While busy is 1, host writes to the command register and to the data register have no effect.
- R9: Accesses the bridge does not answer (another PHY address, or window registers 2 to 31) start no internal access and change no state; their reads return 0xFFFF.
- R10: The bridge holds device, register, write data and direction stable while valid is high and ready low, and returns the read data present in the cycle ready is high.
- R11: Every host strobe gets exactly one acknowledge pulse of one cycle: the cycle after the strobe for answers the bridge gives itself, the cycle after the internal handshake for direct accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_sel | input | 4 | Strapped management address bits 4:1 |
| strap_dual | input | 1 | Shared-bus variant select |
| h_phy | input | 5 | Host PHY address |
| h_reg | input | 5 | Host register address |
| h_wdata | input | 16 | Host write data |
| h_rd | input | 1 | Host read strobe, one cycle |
| h_wr | input | 1 | Host write strobe, one cycle |
| h_ack | output | 1 | Access complete pulse |
| h_rdata | output | 16 | Read data, valid with h_ack |
| dev_valid | output | 1 | Internal request valid |
| dev_we | output | 1 | Internal request is a write |
| dev_id | output | 5 | Internal device number |
| dev_reg | output | 5 | Internal register number |
| dev_wdata | output | 16 | Internal write data |
| dev_ready | input | 1 | Internal request accepted |
| dev_rdata | input | 16 | Internal read data, sampled with ready |

## Verification
A wrong address decode shows up on the very next acknowledge, either as 0xFFFF where device data was due or as an internal access landing on the wrong device, which the bench's device model exposes when the register is read back. A busy flag stuck high makes the polling loop run out, while one that clears early or a lost opcode leaves the device model or the data register holding the wrong value at the first read after busy drops. Early capture of read data is caught because the device model drives garbage until ready.

// File: rtl/smi_bridge_pkg.sv
package smi_bridge_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_DUAL   = 2'd1,
    MODE_MULTI  = 2'd2
  } mode_e;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  localparam int CMD_OP_HI  = 11;
  localparam int CMD_OP_LO  = 10;
  localparam int CMD_DEV_HI = 9;
  localparam int CMD_DEV_LO = 5;
  localparam int CMD_REG_HI = 4;
  localparam int CMD_REG_LO = 0;

  localparam logic [4:0] WIN_CMD  = 5'd0;
  localparam logic [4:0] WIN_DATA = 5'd1;
endpackage

// File: rtl/smi_bridge_decode.sv
module smi_bridge_decode
  import smi_bridge_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-2:0] strap_sel,
  input  logic          strap_dual,
  input  logic [AW-1:0] phy,
  output mode_e         mode,
  output logic          hit,
  output logic [AW-1:0] dev
);
  localparam logic [AW-2:0] STRAP_ZERO = '0;

  always_comb begin
    if (strap_dual) begin
      mode = MODE_DUAL;
      hit  = (phy[AW-1] == strap_sel[AW-2]);
      dev  = {1'b0, phy[AW-2:0]};
    end else if (strap_sel == STRAP_ZERO) begin
      mode = MODE_SINGLE;
      hit  = 1'b1;
      dev  = phy;
    end else begin
      mode = MODE_MULTI;
      hit  = (phy == {strap_sel, 1'b0});
      dev  = phy;
    end
  end
endmodule

// File: rtl/smi_bridge_initiator.sv
module smi_bridge_initiator #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_we,
  input  logic [AW-1:0] start_dev,
  input  logic [AW-1:0] start_reg,
  input  logic [DW-1:0] start_wdata,
  output logic          dev_valid,
  output logic          dev_we,
  output logic [AW-1:0] dev_id,
  output logic [AW-1:0] dev_reg,
  output logic [DW-1:0] dev_wdata,
  input  logic          dev_ready,
  output logic          hs
);
  assign hs = dev_valid & dev_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_valid <= 1'b0;
      dev_we    <= 1'b0;
      dev_id    <= '0;
      dev_reg   <= '0;
      dev_wdata <= '0;
    end else if (hs) begin
      dev_valid <= 1'b0;
    end else if (start && !dev_valid) begin
      dev_valid <= 1'b1;
      dev_we    <= start_we;
      dev_id    <= start_dev;
      dev_reg   <= start_reg;
      dev_wdata <= start_wdata;
    end
  end
endmodule

// File: rtl/smi_bridge_ind_regs.sv
module smi_bridge_ind_regs
  import smi_bridge_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_cmd,
  input  logic          wr_data,
  input  logic [DW-1:0] wdata,
  input  logic          cmd_go,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_dev,
  input  logic [AW-1:0] cmd_reg,
  input  logic          hs,
  input  logic [DW-1:0] rdata_in,
  output logic [DW-1:0] cmd_view,
  output logic [DW-1:0] data_q,
  output logic          busy,
  output logic          launch,
  output logic          op_we,
  output logic [AW-1:0] tgt_dev,
  output logic [AW-1:0] tgt_reg
);
  logic       bad_q;
  logic [1:0] op_q;
  logic       op_ok;

  assign op_ok = (cmd_op == OP_WRITE) || (cmd_op == OP_READ);
  assign op_we = (op_q == OP_WRITE);

  always_comb begin
    cmd_view = '0;
    cmd_view[DW-1] = busy;
    cmd_view[CMD_OP_HI:CMD_OP_LO]   = op_q;
    cmd_view[CMD_DEV_HI:CMD_DEV_LO] = tgt_dev;
    cmd_view[CMD_REG_HI:CMD_REG_LO] = tgt_reg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      bad_q   <= 1'b0;
      launch  <= 1'b0;
      op_q    <= '0;
      tgt_dev <= '0;
      tgt_reg <= '0;
      data_q  <= '0;
    end else begin
      launch <= 1'b0;
      if (bad_q) begin
        busy  <= 1'b0;
        bad_q <= 1'b0;
      end
      if (busy && hs && !bad_q) begin
        busy <= 1'b0;
        if (op_q == OP_READ) data_q <= rdata_in;
      end
      if (!busy) begin
        if (wr_data) data_q <= wdata;
        if (wr_cmd) begin
          op_q    <= cmd_op;
          tgt_dev <= cmd_dev;
          tgt_reg <= cmd_reg;
          if (cmd_go) begin
            busy <= 1'b1;
            if (op_ok) launch <= 1'b1;
            else       bad_q  <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/smi_bridge.sv
module smi_bridge
  import smi_bridge_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-2:0] strap_sel,
  input  logic          strap_dual,
  input  logic [AW-1:0] h_phy,
  input  logic [AW-1:0] h_reg,
  input  logic [DW-1:0] h_wdata,
  input  logic          h_rd,
  input  logic          h_wr,
  output logic          h_ack,
  output logic [DW-1:0] h_rdata,
  output logic          dev_valid,
  output logic          dev_we,
  output logic [AW-1:0] dev_id,
  output logic [AW-1:0] dev_reg,
  output logic [DW-1:0] dev_wdata,
  input  logic          dev_ready,
  input  logic [DW-1:0] dev_rdata
);
  localparam logic [DW-1:0] MISS_VAL = '1;

  mode_e         mode;
  logic          hit;
  logic [AW-1:0] dir_dev;
  logic          is_multi;
  logic          strobe;
  logic          dir_start;
  logic          sel_cmd;
  logic          sel_data;
  logic          hs;
  logic          dir_pend;
  logic          dir_rd_q;

  logic [DW-1:0] cmd_view;
  logic [DW-1:0] data_q;
  logic          ind_busy;
  logic          launch;
  logic          op_we;
  logic [AW-1:0] tgt_dev;
  logic [AW-1:0] tgt_reg;

  logic          st_go;
  logic          st_we;
  logic [AW-1:0] st_dev;
  logic [AW-1:0] st_reg;
  logic [DW-1:0] st_wdata;

  smi_bridge_decode #(.AW(AW)) u_decode (
    .strap_sel  (strap_sel),
    .strap_dual (strap_dual),
    .phy        (h_phy),
    .mode       (mode),
    .hit        (hit),
    .dev        (dir_dev)
  );

  assign is_multi  = (mode == MODE_MULTI);
  assign strobe    = h_rd | h_wr;
  assign dir_start = strobe & hit & ~is_multi;
  assign sel_cmd   = is_multi & hit & (h_reg == WIN_CMD);
  assign sel_data  = is_multi & hit & (h_reg == WIN_DATA);

  smi_bridge_ind_regs #(.AW(AW), .DW(DW)) u_ind (
    .clk      (clk),
    .rst      (rst),
    .wr_cmd   (h_wr & sel_cmd),
    .wr_data  (h_wr & sel_data),
    .wdata    (h_wdata),
    .cmd_go   (h_wdata[DW-1]),
    .cmd_op   (h_wdata[CMD_OP_HI:CMD_OP_LO]),
    .cmd_dev  (h_wdata[CMD_DEV_HI:CMD_DEV_LO]),
    .cmd_reg  (h_wdata[CMD_REG_HI:CMD_REG_LO]),
    .hs       (hs),
    .rdata_in (dev_rdata),
    .cmd_view (cmd_view),
    .data_q   (data_q),
    .busy     (ind_busy),
    .launch   (launch),
    .op_we    (op_we),
    .tgt_dev  (tgt_dev),
    .tgt_reg  (tgt_reg)
  );

  always_comb begin
    if (is_multi) begin
      st_go    = launch;
      st_we    = op_we;
      st_dev   = tgt_dev;
      st_reg   = tgt_reg;
      st_wdata = data_q;
    end else begin
      st_go    = dir_start;
      st_we    = h_wr;
      st_dev   = dir_dev;
      st_reg   = h_reg;
      st_wdata = h_wdata;
    end
  end

  smi_bridge_initiator #(.AW(AW), .DW(DW)) u_init (
    .clk         (clk),
    .rst         (rst),
    .start       (st_go),
    .start_we    (st_we),
    .start_dev   (st_dev),
    .start_reg   (st_reg),
    .start_wdata (st_wdata),
    .dev_valid   (dev_valid),
    .dev_we      (dev_we),
    .dev_id      (dev_id),
    .dev_reg     (dev_reg),
    .dev_wdata   (dev_wdata),
    .dev_ready   (dev_ready),
    .hs          (hs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_pend <= 1'b0;
      dir_rd_q <= 1'b0;
      h_ack    <= 1'b0;
      h_rdata  <= '0;
    end else begin
      h_ack <= 1'b0;
      if (dir_pend && hs) begin
        dir_pend <= 1'b0;
        h_ack    <= 1'b1;
        if (dir_rd_q) h_rdata <= dev_rdata;
      end else if (dir_start) begin
        dir_pend <= 1'b1;
        dir_rd_q <= h_rd;
      end else if (strobe) begin
        h_ack <= 1'b1;
        if (h_rd) begin
          if (sel_cmd)       h_rdata <= cmd_view;
          else if (sel_data) h_rdata <= data_q;
          else               h_rdata <= MISS_VAL;
        end
      end
    end
  end
endmodule

// File: rtl/smi_bridge_chk.sv
module smi_bridge_chk #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          h_rd,
  input logic          h_wr,
  input logic [AW-1:0] h_reg,
  input logic          cmd_go,
  input logic [1:0]    cmd_op,
  input logic          h_ack,
  input logic [DW-1:0] h_rdata,
  input logic          hit,
  input logic          is_multi,
  input logic          ind_busy,
  input logic          dev_valid,
  input logic          dev_ready,
  input logic          dev_we,
  input logic [AW-1:0] dev_id,
  input logic [AW-1:0] dev_reg,
  input logic [DW-1:0] dev_wdata
);
  localparam logic [DW-1:0] ALL_ONES = '1;
  localparam logic [AW-1:0] REG_ZERO = '0;

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!ind_busy && !dev_valid)); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (dev_valid && !dev_ready) |=> (dev_valid && $stable(dev_id) && $stable(dev_reg)
                                   && $stable(dev_wdata) && $stable(dev_we))); // R10

  AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    (h_rd && !hit) |=> (h_ack && h_rdata == ALL_ONES)); // R9

  AST_MISS_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    ((h_rd || h_wr) && !hit && !ind_busy && !dev_valid) |=> !dev_valid); // R9

  AST_BAD_OP_PULSE: assert property (@(posedge clk) disable iff (rst)
    (h_wr && is_multi && hit && h_reg == REG_ZERO && !ind_busy && cmd_go
     && cmd_op != 2'b01 && cmd_op != 2'b10) |=> (ind_busy ##1 !ind_busy)); // R7

  AST_WINDOW_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    (is_multi && dev_valid) |-> ind_busy); // R5
endmodule

bind smi_bridge smi_bridge_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .h_rd      (h_rd),
  .h_wr      (h_wr),
  .h_reg     (h_reg),
  .cmd_go    (h_wdata[DW-1]),
  .cmd_op    (h_wdata[11:10]),
  .h_ack     (h_ack),
  .h_rdata   (h_rdata),
  .hit       (hit),
  .is_multi  (is_multi),
  .ind_busy  (ind_busy),
  .dev_valid (dev_valid),
  .dev_ready (dev_ready),
  .dev_we    (dev_we),
  .dev_id    (dev_id),
  .dev_reg   (dev_reg),
  .dev_wdata (dev_wdata)
);

// File: tb/smi_bridge_bench.sv
module smi_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  strap_sel = 4'd0;
  logic        strap_dual = 1'b0;
  logic [4:0]  h_phy = '0;
  logic [4:0]  h_reg = '0;
  logic [15:0] h_wdata = '0;
  logic        h_rd = 1'b0;
  logic        h_wr = 1'b0;
  logic        h_ack;
  logic [15:0] h_rdata;
  logic        dev_valid;
  logic        dev_we;
  logic [4:0]  dev_id;
  logic [4:0]  dev_reg;
  logic [15:0] dev_wdata;
  logic        dev_ready;
  logic [15:0] dev_rdata;

  int n_chk = 0;
  int n_err = 0;
  int n_acc = 0;
  int lat = 0;
  int cnt = 0;
  logic [15:0] mem [0:1023];
  logic [15:0] ref_mem [0:1023];

  always #5 clk = ~clk;

  smi_bridge u_smi_bridge (
    .clk(clk), .rst(rst), .strap_sel(strap_sel), .strap_dual(strap_dual),
    .h_phy(h_phy), .h_reg(h_reg), .h_wdata(h_wdata), .h_rd(h_rd), .h_wr(h_wr),
    .h_ack(h_ack), .h_rdata(h_rdata),
    .dev_valid(dev_valid), .dev_we(dev_we), .dev_id(dev_id), .dev_reg(dev_reg),
    .dev_wdata(dev_wdata), .dev_ready(dev_ready), .dev_rdata(dev_rdata)
  );

  // device model: garbage until ready so early capture is visible
  assign dev_ready = dev_valid && (cnt >= lat);
  assign dev_rdata = dev_ready ? mem[{dev_id, dev_reg}] : 16'hDEAD;

  always @(posedge clk) begin
    if (!dev_valid || dev_ready) cnt <= 0;
    else                         cnt <= cnt + 1;
    if (dev_valid && dev_ready) begin
      n_acc <= n_acc + 1;
      if (dev_we) mem[{dev_id, dev_reg}] <= dev_wdata;
    end
  end

  function automatic logic [15:0] pat(input int d, input int r);
    return {d[4:0], r[4:0], 6'h15};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                      input logic [15:0] wd, output logic [15:0] rd);
    bit seen;
    @(negedge clk);
    h_phy = phy; h_reg = rg; h_wdata = wd; h_wr = wr; h_rd = !wr;
    @(negedge clk);
    h_rd = 1'b0; h_wr = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (h_ack) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    rd = h_rdata;
    if (!seen) begin
      n_chk++; n_err++;
      $display("FAIL R11: no ack got 0 expected 1");
    end
    @(negedge clk);
    chk("R11 ack one cycle", {15'd0, h_ack}, 16'd0);
  endtask

  task automatic do_reset(input logic [3:0] s, input logic d);
    @(negedge clk);
    rst = 1'b1; strap_sel = s; strap_dual = d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic poll_idle(input logic [4:0] me, input string tag);
    logic [15:0] v;
    v = 16'h8000;
    for (int i = 0; i < 64; i++) begin
      host(1'b0, me, 5'd0, 16'd0, v);
      if (!v[15]) break;
    end
    chk(tag, {15'd0, v[15]}, 16'd0);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] rd;
    int a0;
    for (int d = 0; d < 32; d++)
      for (int r = 0; r < 32; r++) begin
        mem[d*32+r] = pat(d, r);
        ref_mem[d*32+r] = pat(d, r);
      end

    // ---------------- window mode, strap 3 -> PHY 6 ----------------
    do_reset(4'd3, 1'b0);
    host(1'b0, 5'd6, 5'd0, 16'd0, rd);
    chk("R1 command after reset", rd, 16'h0000);
    host(1'b0, 5'd6, 5'd1, 16'd0, rd);
    chk("R1 data after reset", rd, 16'h0000);
    chk("R1 no access", 16'(n_acc), 16'd0);

    // R9: every other PHY address and window registers 2..31 miss
    for (int p = 0; p < 32; p++)
      if (p != 6) begin
        host(1'b0, 5'(p), 5'd0, 16'd0, rd);
        chk("R9 other phy", rd, 16'hFFFF);
      end
    for (int r = 2; r < 32; r++) begin
      host(1'b0, 5'd6, 5'(r), 16'd0, rd);
      chk("R9 window reg", rd, 16'hFFFF);
      host(1'b1, 5'd6, 5'(r), 16'h8421, rd);
    end
    host(1'b1, 5'd7, 5'd0, 16'h8400, rd);
    host(1'b1, 5'd4, 5'd1, 16'h5555, rd);
    host(1'b0, 5'd6, 5'd0, 16'd0, rd);
    chk("R9 command untouched", rd, 16'h0000);
    host(1'b0, 5'd6, 5'd1, 16'd0, rd);
    chk("R9 data untouched", rd, 16'h0000);
    chk("R9 no access", 16'(n_acc), 16'd0);

    // R5 / R4: indirect writes
    lat = 2;
    for (int k = 0; k < 3; k++) begin
      int d, r;
      logic [15:0] v, cmd;
      d = (k == 0) ? 0 : (k == 1) ? 5 : 31;
      r = (k == 0) ? 0 : (k == 1) ? 17 : 31;
      v = 16'((d * 977 + r * 31) ^ 16'hA5A5);
      cmd = 16'h8400 | 16'(d << 5) | 16'(r);
      host(1'b1, 5'd6, 5'd1, v, rd);
      host(1'b1, 5'd6, 5'd0, cmd, rd);
      poll_idle(5'd6, "R5 busy clears");
      ref_mem[d*32+r] = v;
      chk("R5 device written", mem[d*32+r], v);
      host(1'b0, 5'd6, 5'd0, 16'd0, rd);
      chk("R4 command readback", rd, cmd & 16'h7FFF);
    end

    // R6: indirect reads
    for (int k = 0; k < 4; k++) begin
      int d, r;
      d = k * 9 + 1;
      r = 31 - k * 7;
      lat = k;
      host(1'b1, 5'd6, 5'd0, 16'h8800 | 16'(d << 5) | 16'(r), rd);
      poll_idle(5'd6, "R6 busy clears");
      host(1'b0, 5'd6, 5'd1, 16'd0, rd);
      chk("R6 read result", rd, ref_mem[d*32+r]);
    end

    // R7: bad opcodes and commands without busy
    a0 = n_acc;
    host(1'b1, 5'd6, 5'd1, 16'h0BAD, rd);
    host(1'b1, 5'd6, 5'd0, 16'h8000 | 16'(2 << 5) | 16'd3, rd);
    @(negedge clk);
    host(1'b0, 5'd6, 5'd0, 16'd0, rd);
    chk("R7 op 00 busy clear", rd, 16'(2 << 5) | 16'd3);
    host(1'b1, 5'd6, 5'd0, 16'h8C00 | 16'(4 << 5) | 16'd1, rd);
    @(negedge clk);
    host(1'b0, 5'd6, 5'd0, 16'd0, rd);
    chk("R7 op 11 busy clear", rd, 16'h0C00 | 16'(4 << 5) | 16'd1);
    host(1'b1, 5'd6, 5'd0, 16'h0400 | 16'(8 << 5) | 16'd8, rd);
    host(1'b0, 5'd6, 5'd0, 16'd0, rd);
    chk("R7 no-busy command stored", rd, 16'h0400 | 16'(8 << 5) | 16'd8);
    chk("R7 no access", 16'(n_acc - a0), 16'd0);
    chk("R7 device unchanged", mem[8*32+8], ref_mem[8*32+8]);

    // R8: writes while busy are ignored
    lat = 8;
    host(1'b1, 5'd6, 5'd1, 16'h1234, rd);
    host(1'b1, 5'd6, 5'd0, 16'h8400 | 16'(3 << 5) | 16'd4, rd);
    host(1'b1, 5'd6, 5'd1, 16'hBEEF, rd);
    host(1'b1, 5'd6, 5'd0, 16'h8800 | 16'(9 << 5) | 16'd9, rd);
    poll_idle(5'd6, "R8 busy clears");
    ref_mem[3*32+4] = 16'h1234;
    chk("R8 device got first data", mem[3*32+4], 16'h1234);
    host(1'b0, 5'd6, 5'd0, 16'd0, rd);
    chk("R8 command kept", rd, 16'h0400 | 16'(3 << 5) | 16'd4);
    host(1'b0, 5'd6, 5'd1, 16'd0, rd);
    chk("R8 data kept", rd, 16'h1234);

    // ---------------- single mode: full sweep ----------------
    do_reset(4'd0, 1'b0);
    for (int p = 0; p < 32; p++)
      for (int r = 0; r < 32; r++) begin
        lat = (p + r) % 4;
        a0 = n_acc;
        host(1'b0, 5'(p), 5'(r), 16'd0, rd);
        chk("R2 R10 direct read", rd, ref_mem[p*32+r]);
        chk("R2 one access", 16'(n_acc - a0), 16'd1);
      end
    for (int p = 0; p < 32; p++) begin
      logic [15:0] v;
      int r;
      r = (p * 3) % 32;
      v = 16'((p * 257) ^ 16'h3C3C);
      lat = p % 3;
      host(1'b1, 5'(p), 5'(r), v, rd);
      ref_mem[p*32+r] = v;
      chk("R2 direct write", mem[p*32+r], v);
      host(1'b0, 5'(p), 5'(r), 16'd0, rd);
      chk("R2 direct readback", rd, v);
    end

    // ---------------- shared-bus mode ----------------
    for (int half = 0; half < 2; half++) begin
      do_reset(half == 0 ? 4'b1000 : 4'b0110, 1'b1);
      lat = 1;
      for (int p = 0; p < 32; p++) begin
        bool_blk: begin
          bit mine;
          mine = (half == 0) ? (p >= 16) : (p < 16);
          a0 = n_acc;
          host(1'b0, 5'(p), 5'd7, 16'd0, rd);
          if (mine) begin
            chk("R3 answered", rd, ref_mem[(p % 16)*32+7]);
            chk("R3 one access", 16'(n_acc - a0), 16'd1);
          end else begin
            chk("R3 R9 miss", rd, 16'hFFFF);
            chk("R3 R9 no access", 16'(n_acc - a0), 16'd0);
          end
        end
      end
    end
    do_reset(4'b1000, 1'b1);
    host(1'b1, 5'd20, 5'd9, 16'h7E57, rd);
    ref_mem[4*32+9] = 16'h7E57;
    chk("R3 write lands on offset device", mem[4*32+9], 16'h7E57);
    host(1'b1, 5'd4, 5'd9, 16'h0000, rd);
    chk("R3 R9 miss write ignored", mem[4*32+9], 16'h7E57);

    summary();
  end
endmodule